// File: doc/BRIEF.md
# Timer Prescaler with Selectable Asynchronous Base Clock

This block generates the count enable for a timer that can also serve as a real-time counter. A base tick is taken from one of three sources. In synchronous mode the base tick is the system clock itself, so it is present on every cycle. In asynchronous mode the base tick comes from the rising edges of one of two external pins: a crystal-oscillator input or an alternate clock pin. A second select bit chooses which pin is used.

A 10-bit free-running prescaler advances once on each base tick. A 3-bit clock-select value sets what reaches the timer. The value 0 stops the timer. The value 1 passes every base tick. The values 2 to 7 pass one base tick in 8, 32, 64, 128, 256 or 1024.

Software clears the prescaler by writing a clear request. The request stays pending and readable until the next base tick. On that tick the prescaler is cleared and the request drops. The timer and its CPU-side synchronisation are outside this block.

Top module: `rtc_prescaler`

## Requirements
- R1: While reset is asserted and directly after it, the prescaler holds 0, `count_en` is low and `clear_busy` is low.
- R2: With `async_mode` = 0 the prescaler advances on every system clock cycle. Activity on `xtal_pin` and `alt_pin` has no effect on `count_en`.
- R3: With `async_mode` = 1, each rising edge of the selected pin produces exactly one base tick, within three clock cycles of the edge. `pin_sel` = 0 selects `xtal_pin` and `pin_sel` = 1 selects `alt_pin`. Edges on the pin that is not selected produce no base tick.
- R4: With `clk_sel` = 0, `count_en` stays low, but the prescaler keeps advancing. When a tap is selected afterwards, its pulses keep the phase that the uninterrupted count would have given.
- R5: With `clk_sel` = 1, `count_en` equals the base tick.
- R6: The `clk_sel` values 2, 3, 4, 5, 6 and 7 select divide-by 8, 32, 64, 128, 256 and 1024. For a divide-by-N tap, `count_en` is a one-cycle pulse. It is raised on a base tick when the low log2(N) prescaler bits are all ones. The first such pulse comes on the N-th base tick after a clear.
- R7: A pulse on `clear_req` sets `clear_busy` at the next clock edge. On the next base tick the prescaler goes to 0 and `clear_busy` drops. No divided-tap pulse is produced on that tick.
- R8: In asynchronous mode, without base ticks the prescaler holds its value, `count_en` stays low, and a pending clear stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_mode | input | 1 | 1 = base tick taken from an external pin |
| pin_sel | input | 1 | External pin choice: 0 crystal input, 1 alternate clock pin |
| xtal_pin | input | 1 | Crystal-oscillator clock input |
| alt_pin | input | 1 | Alternate external clock input |
| clk_sel | input | 3 | 0 stop, 1 undivided, 2..7 divide by 8/32/64/128/256/1024 |
| clear_req | input | 1 | One-cycle request to clear the prescaler |
| count_en | output | 1 | Timer count enable, one-cycle pulse |
| clear_busy | output | 1 | Clear request pending |

## Verification
The hardest case to reach is a clear whose effective tick lands exactly on a cycle in which the divide-by-8 tap would otherwise fire. The bench first clears the prescaler to reach a known phase. It then counts six cycles and issues the next request so that the pending clear meets the tick at count 7, where the pulse must be absent. A second hard case is a clear left pending in asynchronous mode. The bench holds both pins still and checks that the clear waits, then releases a single crystal edge that completes it.

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PRESC_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_mode,
  input  logic       pin_sel,
  input  logic       xtal_pin,
  input  logic       alt_pin,
  input  logic [2:0] clk_sel,
  input  logic       clear_req,
  output logic       count_en,
  output logic       clear_busy
);
  localparam int SH_W = SYNC_STAGES + 1;
  localparam logic [PRESC_W-1:0] M8    = PRESC_W'(7);
  localparam logic [PRESC_W-1:0] M32   = PRESC_W'(31);
  localparam logic [PRESC_W-1:0] M64   = PRESC_W'(63);
  localparam logic [PRESC_W-1:0] M128  = PRESC_W'(127);
  localparam logic [PRESC_W-1:0] M256  = PRESC_W'(255);
  localparam logic [PRESC_W-1:0] M1024 = PRESC_W'(1023);

  logic [SH_W-1:0]    xtal_sh, alt_sh;
  logic               xtal_rise, alt_rise, base_tick, tap_hit;
  logic [PRESC_W-1:0] presc;

  // per-pin synchronizer and rising-edge detector; selection after detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xtal_sh <= '0;
      alt_sh  <= '0;
    end else begin
      xtal_sh <= {xtal_sh[SH_W-2:0], xtal_pin};
      alt_sh  <= {alt_sh[SH_W-2:0], alt_pin};
    end

  assign xtal_rise = xtal_sh[SH_W-2] & ~xtal_sh[SH_W-1];
  assign alt_rise  = alt_sh[SH_W-2] & ~alt_sh[SH_W-1];
  assign base_tick = !async_mode ? 1'b1 : (pin_sel ? alt_rise : xtal_rise);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc      <= '0;
      clear_busy <= 1'b0;
    end else if (base_tick && clear_busy) begin
      presc      <= '0;
      clear_busy <= clear_req;
    end else begin
      if (base_tick) presc <= presc + 1'b1;
      if (clear_req) clear_busy <= 1'b1;
    end

  always_comb
    case (clk_sel)
      3'd0:    tap_hit = 1'b0;
      3'd1:    tap_hit = 1'b1;
      3'd2:    tap_hit = (presc & M8)    == M8;
      3'd3:    tap_hit = (presc & M32)   == M32;
      3'd4:    tap_hit = (presc & M64)   == M64;
      3'd5:    tap_hit = (presc & M128)  == M128;
      3'd6:    tap_hit = (presc & M256)  == M256;
      default: tap_hit = (presc & M1024) == M1024;
    endcase

  assign count_en = base_tick && tap_hit && (clk_sel == 3'd1 || !clear_busy);

  assert_enable_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> base_tick);
  assert_stopped_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !count_en);
  assert_sync_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !async_mode |-> base_tick);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && clk_sel >= 3'd2 && $stable(clk_sel)) |=> !(count_en && $stable(clk_sel)));
  assert_clear_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_busy && base_tick && !clear_req) |=> (presc == '0 && !clear_busy));
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick) |=> $stable(presc));
endmodule

// File: tb/rtc_prescaler_test.sv
`timescale 1ns/1ps
module rtc_prescaler_test;
  logic clk = 0, rst_n = 0, async_mode = 0, pin_sel = 0, xtal_pin = 0, alt_pin = 0, clear_req = 0;
  logic [2:0] clk_sel = 0;
  logic count_en, clear_busy;
  int n_cmp = 0, n_bad = 0, pulses = 0;

  rtc_prescaler uut (.clk(clk), .rst_n(rst_n), .async_mode(async_mode), .pin_sel(pin_sel),
    .xtal_pin(xtal_pin), .alt_pin(alt_pin), .clk_sel(clk_sel), .clear_req(clear_req),
    .count_en(count_en), .clear_busy(clear_busy));

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && count_en) pulses++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sync_clear;
    @(negedge clk) clear_req = 1;
    @(negedge clk) clear_req = 0;
    check(clear_busy == 1, "R7 busy set", clear_busy, 1);
    @(negedge clk);
    check(clear_busy == 0, "R7 busy dropped", clear_busy, 0);
  endtask

  task automatic pin_edges(input logic use_alt, input int n);
    for (int k = 0; k < n; k++) begin
      if (use_alt) alt_pin = 1; else xtal_pin = 1;
      repeat (4) @(negedge clk);
      if (use_alt) alt_pin = 0; else xtal_pin = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(count_en == 0 && clear_busy == 0, "R1 reset outputs", {count_en, clear_busy}, 0);
    rst_n = 1;
    @(negedge clk);
    check(count_en == 0 && clear_busy == 0, "R1 after reset", {count_en, clear_busy}, 0);
  endtask

  task automatic t_tap(input logic [2:0] sel, input int div);
    int bad = 0;
    clk_sel = sel;
    sync_clear;
    for (int i = 0; i < 2 * div + 4; i++) begin
      logic exp_v;
      exp_v = ((i % div) == div - 1);
      if (count_en !== exp_v) bad++;
      if (i < 2 * div + 3) @(negedge clk);
    end
    check(bad == 0, div == 1 ? "R5 undivided" : "R6 divided tap", bad, 0);
  endtask

  task automatic t_stop_keeps_count;
    int bad = 0;
    clk_sel = 3'd0;
    sync_clear;
    for (int i = 0; i < 303; i++) begin
      if (i == 300) clk_sel = 3'd2;
      if (i >= 300 && count_en !== ((i % 8) == 7)) bad++;
      if (i < 300 && count_en !== 1'b0) bad++;
      @(negedge clk);
    end
    for (int i = 303; i < 340; i++) begin
      if (count_en !== ((i % 8) == 7)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R4 stop then resume phase", bad, 0);
  endtask

  task automatic t_clear_on_tap;
    clk_sel = 3'd2;
    sync_clear;
    repeat (6) @(negedge clk);
    clear_req = 1;
    @(negedge clk) clear_req = 0;
    check(clear_busy == 1, "R7 pending at count 7", clear_busy, 1);
    check(count_en == 0, "R7 pulse suppressed on clearing tick", count_en, 0);
    @(negedge clk);
    check(clear_busy == 0, "R7 cleared", clear_busy, 0);
    repeat (6) @(negedge clk);
    check(count_en == 0, "R7 no pulse before new phase", count_en, 0);
    @(negedge clk);
    check(count_en == 1, "R7 pulse on 8th tick after clear", count_en, 1);
  endtask

  task automatic t_sync_ignores_pins;
    int bad = 0;
    async_mode = 0; clk_sel = 3'd1;
    for (int i = 0; i < 40; i++) begin
      xtal_pin = i[1]; alt_pin = i[2];
      @(negedge clk);
      if (count_en !== 1'b1) bad++;
    end
    xtal_pin = 0; alt_pin = 0;
    check(bad == 0, "R2 sync mode ignores pins", bad, 0);
  endtask

  task automatic t_async;
    int p0;
    async_mode = 1; pin_sel = 0; clk_sel = 3'd2;
    repeat (6) @(negedge clk);
    @(negedge clk) clear_req = 1;
    @(negedge clk) clear_req = 0;
    p0 = pulses;
    repeat (20) @(negedge clk);
    check(clear_busy == 1, "R8 clear waits for tick", clear_busy, 1);
    check(pulses == p0, "R8 no pulse without tick", pulses - p0, 0);
    pin_edges(0, 1);
    check(clear_busy == 0, "R8 clear done on edge", clear_busy, 0);
    p0 = pulses;
    pin_edges(0, 64);
    repeat (6) @(negedge clk);
    check(pulses - p0 == 8, "R6 async divide by 8", pulses - p0, 8);
    clk_sel = 3'd1;
    p0 = pulses;
    pin_edges(0, 20);
    repeat (6) @(negedge clk);
    check(pulses - p0 == 20, "R3 crystal edges", pulses - p0, 20);
    p0 = pulses;
    pin_edges(1, 10);
    repeat (6) @(negedge clk);
    check(pulses - p0 == 0, "R3 unselected pin ignored", pulses - p0, 0);
    pin_sel = 1;
    repeat (4) @(negedge clk);
    p0 = pulses;
    pin_edges(1, 10);
    repeat (6) @(negedge clk);
    check(pulses - p0 == 10, "R3 alternate pin edges", pulses - p0, 10);
    p0 = pulses;
    pin_edges(0, 10);
    repeat (6) @(negedge clk);
    check(pulses - p0 == 0, "R3 crystal ignored when alt chosen", pulses - p0, 0);
    async_mode = 0; pin_sel = 0;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_tap(3'd1, 1);
    t_tap(3'd2, 8);
    t_tap(3'd3, 32);
    t_tap(3'd4, 64);
    t_tap(3'd5, 128);
    t_tap(3'd6, 256);
    t_tap(3'd7, 1024);
    t_stop_keeps_count;
    t_clear_on_tap;
    t_sync_ignores_pins;
    t_async;
    finish_run;
  end
endmodule